// File: doc/BRIEF.md
# System Interrupt Router

This block sits between the peripherals of a chip and its core event controller. It takes up to two banks of 32 level-sensitive interrupt lines each and captures their levels in per-bank status registers. Each line is gated with a per-bank mask bit. A packed 4-bit assignment field steers each line to one of nine core priority lines, which stand for core levels 7 to 15. A priority line is the OR of every input that is pending, unmasked and assigned to it.

Software reaches the block through a simple single-cycle register port. The port has a write strobe, a word-aligned byte address and a half-width flag, and read data comes back in the same cycle. Through it software reads and writes the mask, assignment and wakeup-enable words, reads the status words, and accesses three 16-bit control words. The wakeup-enable bits and the two writable control words are storage only: they have no effect on the outputs of this block.

Top module: `irq_router`

## Requirements
- R1: Each status bit takes the level of its input at every clock edge. Reading status word b returns inputs 32b+31..32b as they were sampled at the last edge.
- R2: `prio_out[k]` (core level 7+k) is high exactly when at least one input has its status bit and its mask bit at 1 and its assignment field equal to k. An input change shows on `prio_out` after one clock edge, not before. A mask or assignment write shows right after the edge that commits the write.
- R3: The assignment field of input n in bank b lives in assignment word 4b + n/8, at bits (n mod 8)*4+3 down to (n mod 8)*4.
- R4: An assignment field value from 9 to 15 routes its input to no priority line.
- R5: Writes to a status word are discarded. Status keeps following the inputs.
- R6: After a synchronous reset the following values hold. Mask and status words are 0. Wakeup words are 0xFFFFFFFF. The two writable control words are 0. The assignment words 0 to 7 hold 0x22211000, 0x43333332, 0x55555444, 0x66655555, 0x32222220, 0x44433333, 0x00444664 and 0x00000000.
- R7: The three control words are 16 bits wide. A read returns their value zero-extended to 32 bits, and a write to words 0 and 1 keeps only data bits 15:0. Word 2 is a read-only reset vector equal to the `RVEC_VALUE` parameter (0x8F00 by default), and writes to it are discarded.
- R8: A read from a misaligned address (address bits 1:0 not zero) or from an unmapped word returns 0. A write there changes no register and no output.
- R9: With `reg_half` at 1, a read returns only bits 15:0 of the word, zero-extended. A write stores data bits 15:0 zero-extended to 32 bits.
- R10: The byte offsets are as follows: 0x00 software reset, 0x04 system config, 0x08 reset vector, 0x10 + 4b mask of bank b, 0x18 + 4b status, 0x20 + 4b wakeup, and 0x28 + 4w assignment word w (w = 0..7). Mask, wakeup and assignment words read back the full 32 bits last written. Writing a wakeup word leaves `prio_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Level-sensitive peripheral interrupt lines, bank b at bits 32b+31..32b |
| reg_wr | input | 1 | Register write strobe, committed at the clock edge |
| reg_half | input | 1 | 1 selects a 16-bit access |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| prio_out | output | 9 | Core priority request lines, bit k is core level 7+k |

## Verification
The bench builds the block with its default two banks (64 inputs) and an 8-bit address. With these values every one of the 64 word addresses can be read back against its reset value. It also lets the bench drive every input together with every one of the 16 field values, so each field position, the nine valid codes and the seven dead codes are all covered. Pseudo-random mixes of inputs, masks and assignment words then test the OR across inputs that share a level. Directed steps cover the one-edge latency, mask gating, half-width access, ignored writes and a reset in the middle of operation.

// File: rtl/irq_router_pkg.sv
// Package: shared constants, register region type and field helper for the
// interrupt router. Assumes 32-bit register words and 4-bit assignment fields.
package irq_router_pkg;
    localparam int WORD_W          = 32;
    localparam int FIELD_W         = 4;
    localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;
    localparam int BANK_IN         = 32;
    localparam int ASGN_PER_BANK   = BANK_IN / FIELDS_PER_WORD;
    localparam int NUM_LEVELS      = 9;
    localparam int CTRL_W          = 16;
    localparam int WORD_SRST       = 0;
    localparam int WORD_SCFG       = 1;
    localparam int WORD_RVEC       = 2;
    localparam int BANK_FIRST_WORD = 4;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SRST,
        RG_SCFG,
        RG_RVEC,
        RG_MASK,
        RG_STAT,
        RG_WAKE,
        RG_ASGN
    } reg_region_e;

    // Extract assignment field number 'slot' from one assignment word.
    function automatic logic [FIELD_W-1:0] field_of(input logic [WORD_W-1:0] word,
                                                    input int slot);
        return word[slot*FIELD_W +: FIELD_W];
    endfunction
endpackage

// File: rtl/irq_router_status.sv
// Module: status capture. Samples every interrupt line at each clock edge so
// status follows the input level. Assumes the inputs are already synchronous.
module irq_router_status #(
    parameter int IN_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] irq_i,
    output logic [IN_W-1:0] status_o
);
    // Capture input levels; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            status_o <= irq_i;
        end
    end
endmodule

// File: rtl/irq_router_regs.sv
// Module: register file and decode. Holds mask, wakeup, assignment and the two
// writable control words, and drives same-cycle read data. Assumes accesses
// are single-cycle, word-aligned for a hit, and that status comes from outside.
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int          NUM_BANKS   = 2,
    parameter int          ADDR_W      = 8,
    parameter logic [15:0] RVEC_VALUE  = 16'h8F00,
    parameter logic [NUM_BANKS*ASGN_PER_BANK*WORD_W-1:0] ASSIGN_INIT = '0
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    reg_wr,
    input  logic                                    reg_half,
    input  logic [ADDR_W-1:0]                       reg_addr,
    input  logic [WORD_W-1:0]                       reg_wdata,
    input  logic [NUM_BANKS*BANK_IN-1:0]            status_i,
    output logic [WORD_W-1:0]                       reg_rdata,
    output logic [NUM_BANKS*WORD_W-1:0]             mask_o,
    output logic [NUM_BANKS*ASGN_PER_BANK*WORD_W-1:0] asgn_o
);
    localparam int ASGN_WORDS = NUM_BANKS * ASGN_PER_BANK;
    localparam int AIDX_W     = (ASGN_WORDS > 1) ? $clog2(ASGN_WORDS) : 1;
    localparam int BIDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int MASK_FIRST = BANK_FIRST_WORD;
    localparam int STAT_FIRST = MASK_FIRST + NUM_BANKS;
    localparam int WAKE_FIRST = STAT_FIRST + NUM_BANKS;
    localparam int ASGN_FIRST = WAKE_FIRST + NUM_BANKS;
    localparam int MAP_END    = ASGN_FIRST + ASGN_WORDS;

    logic [CTRL_W-1:0]                   srst_q;
    logic [CTRL_W-1:0]                   scfg_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0]    mask_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0]    wake_q;
    logic [ASGN_WORDS-1:0][WORD_W-1:0]   asgn_q;
    logic [NUM_BANKS-1:0][WORD_W-1:0]    stat_w;
    reg_region_e                         region;
    logic [BIDX_W-1:0]                   bidx;
    logic [AIDX_W-1:0]                   aidx;
    logic [WORD_W-1:0]                   wval;
    logic [WORD_W-1:0]                   rd_full;

    assign stat_w = status_i;
    assign mask_o = mask_q;
    assign asgn_o = asgn_q;

    // Decode the address into a register region and an index inside it.
    always_comb begin
        int w;
        w      = int'(reg_addr[ADDR_W-1:2]);
        region = RG_NONE;
        bidx   = '0;
        aidx   = '0;
        if (reg_addr[1:0] == 2'b00) begin
            if (w == WORD_SRST) begin
                region = RG_SRST;
            end else if (w == WORD_SCFG) begin
                region = RG_SCFG;
            end else if (w == WORD_RVEC) begin
                region = RG_RVEC;
            end else if (w >= MASK_FIRST && w < STAT_FIRST) begin
                region = RG_MASK;
                bidx   = BIDX_W'(w - MASK_FIRST);
            end else if (w >= STAT_FIRST && w < WAKE_FIRST) begin
                region = RG_STAT;
                bidx   = BIDX_W'(w - STAT_FIRST);
            end else if (w >= WAKE_FIRST && w < ASGN_FIRST) begin
                region = RG_WAKE;
                bidx   = BIDX_W'(w - WAKE_FIRST);
            end else if (w >= ASGN_FIRST && w < MAP_END) begin
                region = RG_ASGN;
                aidx   = AIDX_W'(w - ASGN_FIRST);
            end
        end
    end

    // Form the write value: half-width writes are zero-extended.
    always_comb begin
        wval = reg_half ? {{(WORD_W-CTRL_W){1'b0}}, reg_wdata[CTRL_W-1:0]} : reg_wdata;
    end

    // Commit register writes; status and reset vector are not writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_q <= '0;
            scfg_q <= '0;
            mask_q <= '0;
            wake_q <= '1;
            asgn_q <= ASSIGN_INIT;
        end else if (reg_wr) begin
            case (region)
                RG_SRST: srst_q       <= wval[CTRL_W-1:0];
                RG_SCFG: scfg_q       <= wval[CTRL_W-1:0];
                RG_MASK: mask_q[bidx] <= wval;
                RG_WAKE: wake_q[bidx] <= wval;
                RG_ASGN: asgn_q[aidx] <= wval;
                default: ;
            endcase
        end
    end

    // Select the full-width read value for the decoded region.
    always_comb begin
        case (region)
            RG_SRST: rd_full = {{(WORD_W-CTRL_W){1'b0}}, srst_q};
            RG_SCFG: rd_full = {{(WORD_W-CTRL_W){1'b0}}, scfg_q};
            RG_RVEC: rd_full = {{(WORD_W-CTRL_W){1'b0}}, RVEC_VALUE};
            RG_MASK: rd_full = mask_q[bidx];
            RG_STAT: rd_full = stat_w[bidx];
            RG_WAKE: rd_full = wake_q[bidx];
            RG_ASGN: rd_full = asgn_q[aidx];
            default: rd_full = '0;
        endcase
    end

    // Narrow the read data for half-width accesses.
    always_comb begin
        reg_rdata = reg_half ? {{(WORD_W-CTRL_W){1'b0}}, rd_full[CTRL_W-1:0]} : rd_full;
    end

    // R5, R7, R8: writes to status, reset vector or unmapped space leave every register unchanged.
    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (region == RG_NONE || region == RG_STAT || region == RG_RVEC))
        |=> ($stable(mask_q) && $stable(wake_q) && $stable(asgn_q)
             && $stable(srst_q) && $stable(scfg_q)));

    // R7: control words never show bits above 15.
    assert_ctrl_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_SRST || region == RG_SCFG) |-> (reg_rdata[WORD_W-1:CTRL_W] == '0));
endmodule

// File: rtl/irq_router_steer.sv
// Module: level steering. For each core priority line, ORs every pending and
// unmasked input whose assignment field selects that line. Purely
// combinational; assumes pend_i is already status AND mask.
module irq_router_steer
    import irq_router_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic [NUM_BANKS*BANK_IN-1:0]                pend_i,
    input  logic [NUM_BANKS*ASGN_PER_BANK*WORD_W-1:0]   asgn_i,
    output logic [NUM_LEVELS-1:0]                       level_o
);
    localparam int IN_W       = NUM_BANKS * BANK_IN;
    localparam int ASGN_WORDS = NUM_BANKS * ASGN_PER_BANK;

    logic [ASGN_WORDS-1:0][WORD_W-1:0] asgn_w;
    logic [IN_W-1:0][FIELD_W-1:0]      fld;

    assign asgn_w = asgn_i;

    // One field per input: word = input/8 across banks, slot = input mod 8.
    for (genvar i = 0; i < IN_W; i++) begin : g_field
        assign fld[i] = field_of(asgn_w[i / FIELDS_PER_WORD], i % FIELDS_PER_WORD);
    end

    // One OR tree per priority line; field codes above 8 match no line.
    for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_level
        logic [IN_W-1:0] hit;
        // Flag inputs that are pending and assigned to line k.
        always_comb begin
            for (int i = 0; i < IN_W; i++) begin
                hit[i] = pend_i[i] && (fld[i] == FIELD_W'(k));
            end
        end
        assign level_o[k] = |hit;
    end
endmodule

// File: rtl/irq_router.sv
// Module: top of the interrupt router. Captures interrupt levels, gates them
// with the masks and steers them to nine core priority lines; exposes all
// state through a single-cycle register port. Assumes synchronous inputs.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int          NUM_BANKS  = 2,
    parameter int          ADDR_W     = 8,
    parameter logic [15:0] RVEC_VALUE = 16'h8F00,
    parameter logic [NUM_BANKS*ASGN_PER_BANK*WORD_W-1:0] ASSIGN_INIT =
        256'h00000000_00444664_44433333_32222220_66655555_55555444_43333332_22211000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_BANKS*BANK_IN-1:0] irq_in,
    input  logic                         reg_wr,
    input  logic                         reg_half,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [WORD_W-1:0]            reg_wdata,
    output logic [WORD_W-1:0]            reg_rdata,
    output logic [NUM_LEVELS-1:0]        prio_out
);
    localparam int IN_W       = NUM_BANKS * BANK_IN;
    localparam int ASGN_WORDS = NUM_BANKS * ASGN_PER_BANK;
    localparam int MAP_END    = BANK_FIRST_WORD + 3 * NUM_BANKS + ASGN_WORDS;

    logic [IN_W-1:0]              status;
    logic [IN_W-1:0]              mask;
    logic [IN_W-1:0]              pend;
    logic [ASGN_WORDS*WORD_W-1:0] asgn;

    irq_router_status #(
        .IN_W (IN_W)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_i    (irq_in),
        .status_o (status)
    );

    irq_router_regs #(
        .NUM_BANKS   (NUM_BANKS),
        .ADDR_W      (ADDR_W),
        .RVEC_VALUE  (RVEC_VALUE),
        .ASSIGN_INIT (ASSIGN_INIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_half  (reg_half),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_i  (status),
        .reg_rdata (reg_rdata),
        .mask_o    (mask),
        .asgn_o    (asgn)
    );

    assign pend = status & mask;

    irq_router_steer #(
        .NUM_BANKS (NUM_BANKS)
    ) u_steer (
        .pend_i  (pend),
        .asgn_i  (asgn),
        .level_o (prio_out)
    );

    // R2: with every input low for a cycle, no priority line is raised after the edge.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |=> (prio_out == '0));

    // R4: each active line needs at least one distinct pending input behind it.
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(prio_out) <= $countones(pend));

    // R8: misaligned or unmapped reads return zero.
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr[1:0] != 2'b00) || (int'(reg_addr[ADDR_W-1:2]) == 3)
         || (int'(reg_addr[ADDR_W-1:2]) >= MAP_END)) |-> (reg_rdata == '0));

    // R7: the reset vector word always reads the configured constant.
    assert_vec_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr[1:0] == 2'b00) && (int'(reg_addr[ADDR_W-1:2]) == WORD_RVEC))
        |-> (reg_rdata == {16'h0000, RVEC_VALUE}));
endmodule

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
    localparam logic [15:0]  B_RVEC = 16'h8F00;
    localparam logic [255:0] B_INIT =
        {32'h00000000, 32'h00444664, 32'h44433333, 32'h32222220,
         32'h66655555, 32'h55555444, 32'h43333332, 32'h22211000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_half = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [8:0]  prio_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] rdv;
    logic [31:0] word;
    logic [31:0] seed;
    logic [63:0] m_irq;
    logic [63:0] m_mask;
    logic [255:0] m_asg;

    always #2 clk = ~clk;

    irq_router #(
        .NUM_BANKS   (2),
        .ADDR_W      (8),
        .RVEC_VALUE  (B_RVEC),
        .ASSIGN_INIT (B_INIT)
    ) u_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .reg_wr    (reg_wr),
        .reg_half  (reg_half),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .prio_out  (prio_out)
    );

    function automatic logic [7:0] a_mask(input int b); return 8'(16 + 4*b); endfunction
    function automatic logic [7:0] a_stat(input int b); return 8'(24 + 4*b); endfunction
    function automatic logic [7:0] a_wake(input int b); return 8'(32 + 4*b); endfunction
    function automatic logic [7:0] a_asg(input int w);  return 8'(40 + 4*w); endfunction

    function automatic logic [31:0] reset_value(input int w);
        if (w == 2) return {16'h0000, B_RVEC};
        if (w == 8 || w == 9) return 32'hFFFF_FFFF;
        if (w >= 10 && w < 18) return B_INIT[(w-10)*32 +: 32];
        return 32'h0;
    endfunction

    function automatic logic [8:0] route(input logic [63:0] irq, input logic [63:0] msk,
                                         input logic [255:0] asg);
        logic [8:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            int v;
            v = int'(asg[(i/8)*32 + (i%8)*4 +: 4]);
            if (irq[i] && msk[i] && v < 9) r[v] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic h);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_half = h;
        @(negedge clk);
        reg_wr = 1'b0; reg_half = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic h, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_half = h;
        #1;
        d = reg_rdata;
        reg_half = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 / R8 / R7: whole address space after reset
        chk("R6 prio after reset", {23'b0, prio_out}, 32'h0);
        for (int w = 0; w < 64; w++) begin
            rd(8'(w*4), 1'b0, rdv);
            chk($sformatf("R6 R8 reset word %0d", w), rdv, reset_value(w));
        end
        rd(8'h29, 1'b0, rdv);
        chk("R8 misaligned read", rdv, 32'h0);

        // R1: status follows inputs; masks 0 keep outputs low (R2)
        @(negedge clk);
        irq_in = 64'hDEAD_BEEF_0123_4567;
        @(negedge clk);
        rd(a_stat(0), 1'b0, rdv); chk("R1 status bank0", rdv, 32'h0123_4567);
        rd(a_stat(1), 1'b0, rdv); chk("R1 status bank1", rdv, 32'hDEAD_BEEF);
        chk("R2 masked off", {23'b0, prio_out}, 32'h0);
        irq_in = 64'h0000_FFFF_8000_0001;
        @(negedge clk);
        rd(a_stat(0), 1'b0, rdv); chk("R1 status bank0 new", rdv, 32'h8000_0001);
        rd(a_stat(1), 1'b0, rdv); chk("R1 status bank1 new", rdv, 32'h0000_FFFF);

        // R5: status writes discarded
        wr(a_stat(0), 32'h1234_5678, 1'b0);
        wr(a_stat(1), 32'hFFFF_0000, 1'b0);
        rd(a_stat(0), 1'b0, rdv); chk("R5 status write ignored b0", rdv, 32'h8000_0001);
        rd(a_stat(1), 1'b0, rdv); chk("R5 status write ignored b1", rdv, 32'h0000_FFFF);

        // R3 / R4 / R2: every input against every field value
        @(negedge clk);
        irq_in = '1;
        for (int w = 0; w < 8; w++) wr(a_asg(w), 32'hFFFF_FFFF, 1'b0);
        wr(a_mask(0), 32'hFFFF_FFFF, 1'b0);
        wr(a_mask(1), 32'hFFFF_FFFF, 1'b0);
        chk("R4 all fields dead", {23'b0, prio_out}, 32'h0);
        for (int n = 0; n < 64; n++) begin
            for (int v = 0; v < 16; v++) begin
                word = 32'hFFFF_FFFF;
                word[(n%8)*4 +: 4] = 4'(v);
                wr(a_asg(n/8), word, 1'b0);
                chk($sformatf("R3 R4 input %0d field %0d", n, v), {23'b0, prio_out},
                    (v < 9) ? (32'h1 << v) : 32'h0);
            end
            word = 32'hFFFF_FFFF;
            word[(n%8)*4 +: 4] = 4'(n % 9);
            wr(a_asg(n/8), word, 1'b0);
            wr(a_mask(n/32), ~(32'h1 << (n%32)), 1'b0);
            chk($sformatf("R2 mask gate input %0d", n), {23'b0, prio_out}, 32'h0);
            wr(a_mask(n/32), 32'hFFFF_FFFF, 1'b0);
            irq_in[n] = 1'b0;
            #1;
            chk($sformatf("R2 latency hold input %0d", n), {23'b0, prio_out}, 32'h1 << (n % 9));
            @(negedge clk);
            chk($sformatf("R2 input drop %0d", n), {23'b0, prio_out}, 32'h0);
            irq_in[n] = 1'b1;
            wr(a_asg(n/8), 32'hFFFF_FFFF, 1'b0);
        end

        // R2: pseudo-random mixes, several inputs sharing levels
        seed = 32'h1357_9BDF;
        for (int t = 0; t < 150; t++) begin
            seed = next_rand(seed); m_mask[31:0] = seed;
            seed = next_rand(seed); m_mask[63:32] = seed;
            for (int w = 0; w < 8; w++) begin
                seed = next_rand(seed); m_asg[w*32 +: 32] = seed;
                wr(a_asg(w), seed, 1'b0);
            end
            wr(a_mask(0), m_mask[31:0], 1'b0);
            wr(a_mask(1), m_mask[63:32], 1'b0);
            seed = next_rand(seed); m_irq[31:0] = seed & next_rand(seed ^ 32'h5A5A_A5A5);
            seed = next_rand(seed); m_irq[63:32] = seed & next_rand(seed ^ 32'h0F0F_F0F0);
            irq_in = m_irq;
            @(negedge clk);
            chk($sformatf("R2 random trial %0d", t), {23'b0, prio_out},
                {23'b0, route(m_irq, m_mask, m_asg)});
        end

        // R10: full-width read back, wakeup has no routing effect
        wr(a_mask(0), 32'hA5A5_5A5A, 1'b0);
        rd(a_mask(0), 1'b0, rdv); chk("R10 mask0 readback", rdv, 32'hA5A5_5A5A);
        m_mask[31:0] = 32'hA5A5_5A5A;
        wr(a_asg(3), 32'h0F1E_2D3C, 1'b0);
        rd(a_asg(3), 1'b0, rdv); chk("R10 assign3 readback", rdv, 32'h0F1E_2D3C);
        m_asg[3*32 +: 32] = 32'h0F1E_2D3C;
        word = {23'b0, prio_out};
        chk("R10 routing after writes", word, {23'b0, route(m_irq, m_mask, m_asg)});
        wr(a_wake(1), 32'h1234_0000, 1'b0);
        rd(a_wake(1), 1'b0, rdv); chk("R10 wake1 readback", rdv, 32'h1234_0000);
        chk("R10 wake write leaves prio", {23'b0, prio_out}, word);

        // R7: control words are 16 bits, reset vector read-only
        wr(8'h00, 32'h1234_ABCD, 1'b0);
        rd(8'h00, 1'b0, rdv); chk("R7 soft reset word", rdv, 32'h0000_ABCD);
        wr(8'h04, 32'hFFFF_0042, 1'b0);
        rd(8'h04, 1'b0, rdv); chk("R7 config word", rdv, 32'h0000_0042);
        wr(8'h08, 32'h0000_1111, 1'b0);
        rd(8'h08, 1'b0, rdv); chk("R7 reset vector constant", rdv, {16'h0, B_RVEC});
        chk("R7 control writes leave prio", {23'b0, prio_out}, word);

        // R9: half-width access
        wr(a_mask(1), 32'hFFFF_5A5A, 1'b1);
        rd(a_mask(1), 1'b0, rdv); chk("R9 half write zero-extends", rdv, 32'h0000_5A5A);
        rd(a_asg(3), 1'b1, rdv); chk("R9 half read low bits", rdv, 32'h0000_2D3C);
        rd(8'h00, 1'b1, rdv); chk("R9 half read control", rdv, 32'h0000_ABCD);

        // R8: unmapped and misaligned writes change nothing
        m_mask[63:32] = 32'h0000_5A5A;
        word = {23'b0, route(m_irq, m_mask, m_asg)};
        wr(8'h0C, 32'hFFFF_FFFF, 1'b0);
        wr(8'h48, 32'hFFFF_FFFF, 1'b0);
        wr(8'h11, 32'h0000_0000, 1'b0);
        rd(a_mask(0), 1'b0, rdv); chk("R8 mask0 untouched", rdv, 32'hA5A5_5A5A);
        rd(8'h48, 1'b0, rdv); chk("R8 unmapped still zero", rdv, 32'h0);
        chk("R8 prio untouched", {23'b0, prio_out}, word);

        // R6: reset in mid-operation
        @(negedge clk);
        irq_in = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(a_mask(0), 1'b0, rdv); chk("R6 mask0 after reset", rdv, 32'h0);
        rd(a_wake(1), 1'b0, rdv); chk("R6 wake1 after reset", rdv, 32'hFFFF_FFFF);
        rd(a_asg(3), 1'b0, rdv); chk("R6 assign3 after reset", rdv, 32'h6665_5555);
        rd(8'h00, 1'b0, rdv); chk("R6 soft reset word after reset", rdv, 32'h0);
        rd(a_stat(0), 1'b0, rdv); chk("R6 status after reset", rdv, 32'h0);
        chk("R6 prio after reset", {23'b0, prio_out}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule